// File: doc/BRIEF.md
# Serial Transceiver with Pending-Flag Status

This block is an asynchronous serial transceiver for eight-bit characters. Its receiver recovers frames from the serial input using an oversampling tick, 16 ticks per bit by default. It can check parity, checks the stop bit and detects a line held low for a whole frame. Its transmitter has a one-word holding buffer in front of a shift register. An eight-bit status register collects pending events. Software clears these flags by writing zeros. It can never set them. A single registered interrupt output is high while any status flag enabled in a mask register is set.

An address-filter mode lets a receiver on a shared line ignore traffic not meant for it. While this mode is on, a correctly framed character is accepted only if it equals a programmable match value. A character with a bad stop bit is accepted anyway, so the fault is still reported.

A simple register port gives access to the block. A write takes effect at the clock edge where `cpu_wr` is high. For a read, `cpu_rdata` holds the selected register from the clock edge where `cpu_rd` is high.

The register offsets are:
- 0: data. A read returns the receive buffer. A write fills the transmit buffer.
- 1: status.
- 2: config. Bit 0 enables parity, bit 1 selects odd parity and bit 2 turns on address filtering.
- 3: match value.
- 4: interrupt mask.

Top module: `sci_status_uart`

## Requirements
- R1: After reset the status register reads 0x03 (only the transmit flags set), `irq` is low and `txd` is high.
- R2: A received frame (low start bit, eight data bits sent LSB first, an optional parity bit, then a stop bit) is loaded into the receive buffer and sets status bit 2 (receive data pending).
- R3: When parity is enabled, a parity bit that differs from the selected sense sets status bit 5. Even parity means the data bits XOR to the parity bit; odd parity means they XOR to its inverse. The word is still loaded.
- R4: A low stop bit in a frame that is not a break sets status bit 6 (framing error), and the word is still loaded.
- R5: A frame whose sampled bits are all low, including parity and stop, sets status bit 3 (break). It does not load the buffer and does not set bit 2. Reception resumes once the line returns high.
- R6: Loading a word while the previous one has not been read through the data register sets status bit 7 (overrun). The buffer then holds the newest word.
- R7: Writing the status register clears each bit written as 0 and keeps each bit written as 1. A write never sets a flag. A hardware event in the same cycle wins over a clear.
- R8: With address filtering on, a correctly framed character that differs from the match value changes neither the buffer nor any flag. A matching one is loaded and sets bits 4 and 2.
- R9: With address filtering on, a character with a low stop bit is loaded whatever its value. It sets bits 6 and 2, so an interrupt enabled on either bit is raised.
- R10: The transmitter sends a low start bit, eight data bits LSB first, the parity bit if enabled, and a high stop bit, each 16 ticks long. `txd` is high whenever it is idle.
- R11: Status bit 1 sets when the buffered word moves into the shift register. Status bit 0 sets when the shift register finishes and no word is waiting.
- R12: `irq` is high one cycle after any status bit whose mask bit is 1 is set, and low when the mask clears all set bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | Oversampling tick, 16 per bit time |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe |
| cpu_addr | input | 3 | Register offset |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Registered read data |
| irq | output | 1 | Interrupt request |

## Verification
The receiver decides on a frame at the middle of its stop bit. The matching status flags and buffer contents become visible two clock cycles later, about eight cycles before the stop bit ends. For this reason the bench reads status and data only after it has finished driving the frame and then held the line idle for 20 more cycles.

A register read returns its value one cycle after the strobe. `irq` follows a status or mask change by one cycle, and the bench waits three cycles before sampling it.

Transmit bits are sampled at bit centres. The first sample is taken 8 cycles after the first low `txd` is seen, and each later sample follows 16 cycles after the one before. The transmit status flags are read once in mid-frame and once after the frame has ended, so each is seen on the correct side of its event.

// File: rtl/uart_pkg.sv
package uart_pkg;
  localparam int ST_W = 8;
  // status bit positions, MSB first
  localparam int ST_OVR  = 7;
  localparam int ST_FRM  = 6;
  localparam int ST_PAR  = 5;
  localparam int ST_ADR  = 4;
  localparam int ST_BRK  = 3;
  localparam int ST_RDY  = 2;
  localparam int ST_BEMP = 1;
  localparam int ST_SEMP = 0;
  localparam logic [ST_W-1:0] ST_RST = 8'h03;

  // register offsets
  localparam int REG_DATA  = 0;
  localparam int REG_STAT  = 1;
  localparam int REG_CFG   = 2;
  localparam int REG_MATCH = 3;
  localparam int REG_MASK  = 4;

  typedef struct packed {
    logic addr_mode;
    logic par_odd;
    logic par_en;
  } cfg_t;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_PARB, RX_STOP, RX_HOLD
  } rx_state_t;
endpackage

// File: rtl/uart_rx.sv
module uart_rx
  import uart_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OSR = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          rxd,
  input  logic          par_en,
  input  logic          par_odd,
  output logic          done,
  output logic [DW-1:0] data,
  output logic          perr,
  output logic          ferr,
  output logic          brk
);
  localparam int CW = $clog2(OSR);
  localparam int BW = $clog2(DW);
  localparam logic [CW-1:0] MID  = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);
  localparam logic [BW-1:0] LASTBIT = BW'(DW - 1);

  logic [1:0]    sync;
  logic          rx_s;
  rx_state_t     state;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bitn;
  logic [DW-1:0] shreg;
  logic          par_bit;
  logic          all_low;
  logic          exp_par;
  logic          brk_now;

  assign rx_s    = sync[1];
  assign exp_par = par_odd ? ~(^shreg) : ^shreg;
  assign brk_now = all_low & ~rx_s;

  always_ff @(posedge clk) begin
    if (rst) sync <= 2'b11;
    else     sync <= {sync[0], rxd};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= RX_IDLE;
      cnt     <= '0;
      bitn    <= '0;
      shreg   <= '0;
      par_bit <= 1'b0;
      all_low <= 1'b0;
      done    <= 1'b0;
      data    <= '0;
      perr    <= 1'b0;
      ferr    <= 1'b0;
      brk     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        RX_IDLE: begin
          if (tick && !rx_s) begin
            state <= RX_START;
            cnt   <= '0;
          end
        end
        RX_START: begin
          if (tick) begin
            if (cnt == MID) begin
              cnt <= '0;
              if (!rx_s) begin
                state   <= RX_DATA;
                bitn    <= '0;
                all_low <= 1'b1;
              end else begin
                state <= RX_IDLE;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        RX_DATA: begin
          if (tick) begin
            if (cnt == LAST) begin
              cnt     <= '0;
              shreg   <= {rx_s, shreg[DW-1:1]};
              all_low <= all_low & ~rx_s;
              if (bitn == LASTBIT) state <= par_en ? RX_PARB : RX_STOP;
              else                 bitn  <= bitn + 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        RX_PARB: begin
          if (tick) begin
            if (cnt == LAST) begin
              cnt     <= '0;
              par_bit <= rx_s;
              all_low <= all_low & ~rx_s;
              state   <= RX_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        RX_STOP: begin
          if (tick) begin
            if (cnt == LAST) begin
              cnt   <= '0;
              done  <= 1'b1;
              data  <= shreg;
              brk   <= brk_now;
              ferr  <= ~rx_s & ~brk_now;
              perr  <= par_en & (par_bit != exp_par) & ~brk_now;
              state <= rx_s ? RX_IDLE : RX_HOLD;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        RX_HOLD: begin
          if (rx_s) state <= RX_IDLE;
        end
        default: state <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_tx.sv
module uart_tx #(
  parameter int DW  = 8,
  parameter int OSR = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          par_en,
  input  logic          par_odd,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          txd,
  output logic          busy,
  output logic          xfer,
  output logic          fin
);
  localparam int FW = DW + 3;
  localparam int CW = $clog2(OSR);
  localparam int LW = $clog2(FW + 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  logic [DW-1:0] buf_q;
  logic          full_q;
  logic [FW-1:0] sh;
  logic [FW-1:0] frame;
  logic [LW-1:0] left;
  logic [CW-1:0] cnt;
  logic          pbit;

  always_comb begin
    pbit  = par_odd ? ~(^buf_q) : ^buf_q;
    frame = {1'b1, (par_en ? pbit : 1'b1), buf_q, 1'b0};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_q  <= '0;
      full_q <= 1'b0;
      sh     <= '1;
      left   <= '0;
      cnt    <= '0;
      busy   <= 1'b0;
      txd    <= 1'b1;
      xfer   <= 1'b0;
      fin    <= 1'b0;
    end else begin
      xfer <= 1'b0;
      fin  <= 1'b0;
      if (!busy) begin
        if (full_q && tick) begin
          txd    <= frame[0];
          sh     <= frame >> 1;
          left   <= par_en ? LW'(FW - 1) : LW'(FW - 2);
          cnt    <= '0;
          busy   <= 1'b1;
          full_q <= 1'b0;
          xfer   <= 1'b1;
        end
      end else if (tick) begin
        if (cnt == LAST) begin
          cnt <= '0;
          if (left == '0) begin
            busy <= 1'b0;
            txd  <= 1'b1;
            fin  <= ~full_q;
          end else begin
            txd  <= sh[0];
            sh   <= sh >> 1;
            left <= left - 1'b1;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
      if (wr_en) begin
        buf_q  <= wr_data;
        full_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_status.sv
module uart_status #(
  parameter int W = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set,
  input  logic         clr_wr,
  input  logic [W-1:0] clr_data,
  output logic [W-1:0] q
);
  logic [W-1:0] keep;
  assign keep = clr_wr ? clr_data : {W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) q <= RST_VAL;
    else     q <= (q & keep) | set;
  end
endmodule

// File: rtl/sci_status_uart.sv
module sci_status_uart
  import uart_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick16,
  input  logic              rxd,
  output logic              txd,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              irq
);
  cfg_t              cfg_q;
  logic [DATA_W-1:0] match_q;
  logic [ST_W-1:0]   mask_q;
  logic [DATA_W-1:0] rx_buf;
  logic              unread;
  logic [ST_W-1:0]   status_q;
  logic [ST_W-1:0]   hw_set;

  logic              rx_done, rx_perr, rx_ferr, rx_brk;
  logic [DATA_W-1:0] rx_data;
  logic              rx_match, rx_load, rd_data;
  logic              tx_busy, tx_xfer, tx_fin;

  logic wr_data_sel, wr_stat_sel, wr_cfg_sel, wr_match_sel, wr_mask_sel;
  assign wr_data_sel  = cpu_wr && (cpu_addr == ADDR_W'(REG_DATA));
  assign wr_stat_sel  = cpu_wr && (cpu_addr == ADDR_W'(REG_STAT));
  assign wr_cfg_sel   = cpu_wr && (cpu_addr == ADDR_W'(REG_CFG));
  assign wr_match_sel = cpu_wr && (cpu_addr == ADDR_W'(REG_MATCH));
  assign wr_mask_sel  = cpu_wr && (cpu_addr == ADDR_W'(REG_MASK));
  assign rd_data      = cpu_rd && (cpu_addr == ADDR_W'(REG_DATA));

  uart_rx #(.DW(DATA_W), .OSR(OSR)) u_rx (
    .clk(clk), .rst(rst), .tick(tick16), .rxd(rxd),
    .par_en(cfg_q.par_en), .par_odd(cfg_q.par_odd),
    .done(rx_done), .data(rx_data), .perr(rx_perr), .ferr(rx_ferr), .brk(rx_brk)
  );

  uart_tx #(.DW(DATA_W), .OSR(OSR)) u_tx (
    .clk(clk), .rst(rst), .tick(tick16),
    .par_en(cfg_q.par_en), .par_odd(cfg_q.par_odd),
    .wr_en(wr_data_sel), .wr_data(cpu_wdata),
    .txd(txd), .busy(tx_busy), .xfer(tx_xfer), .fin(tx_fin)
  );

  assign rx_match = (rx_data == match_q);
  assign rx_load  = rx_done && !rx_brk && (!cfg_q.addr_mode || rx_match || rx_ferr);

  always_comb begin
    hw_set          = '0;
    hw_set[ST_OVR]  = rx_load && unread && !rd_data;
    hw_set[ST_FRM]  = rx_load && rx_ferr;
    hw_set[ST_PAR]  = rx_load && rx_perr;
    hw_set[ST_ADR]  = rx_load && cfg_q.addr_mode && rx_match;
    hw_set[ST_BRK]  = rx_done && rx_brk;
    hw_set[ST_RDY]  = rx_load;
    hw_set[ST_BEMP] = tx_xfer;
    hw_set[ST_SEMP] = tx_fin;
  end

  uart_status #(.W(ST_W), .RST_VAL(ST_RST)) u_stat (
    .clk(clk), .rst(rst), .set(hw_set),
    .clr_wr(wr_stat_sel), .clr_data(ST_W'(cpu_wdata)), .q(status_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q   <= '0;
      match_q <= '0;
      mask_q  <= '0;
      rx_buf  <= '0;
      unread  <= 1'b0;
    end else begin
      if (wr_cfg_sel)   cfg_q   <= cfg_t'(cpu_wdata[$bits(cfg_t)-1:0]);
      if (wr_match_sel) match_q <= cpu_wdata;
      if (wr_mask_sel)  mask_q  <= ST_W'(cpu_wdata);
      if (rx_load) begin
        rx_buf <= rx_data;
        unread <= 1'b1;
      end else if (rd_data) begin
        unread <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      irq <= |(status_q & mask_q);
      if (cpu_rd) begin
        case (int'(cpu_addr))
          REG_DATA:  cpu_rdata <= rx_buf;
          REG_STAT:  cpu_rdata <= DATA_W'(status_q);
          REG_CFG:   cpu_rdata <= DATA_W'(cfg_q);
          REG_MATCH: cpu_rdata <= match_q;
          REG_MASK:  cpu_rdata <= DATA_W'(mask_q);
          default:   cpu_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/sci_status_uart_chk.sv
module sci_status_uart_chk #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  parameter int SW     = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_wr,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic [DATA_W-1:0] cpu_wdata,
  input logic [SW-1:0]     status_q,
  input logic [SW-1:0]     hw_set,
  input logic [SW-1:0]     mask_q,
  input logic              irq,
  input logic              txd,
  input logic              tx_busy,
  input logic              rx_load,
  input logic              addr_mode
);
  logic stat_wr;
  assign stat_wr = cpu_wr && (cpu_addr == ADDR_W'(1));

  AST_NO_SW_SET: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(hw_set)) == '0)); // R7
  AST_ONES_KEEP: assert property (@(posedge clk) disable iff (rst)
    stat_wr |=> (($past(status_q) & $past(SW'(cpu_wdata)) & ~status_q) == '0)); // R7
  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (rst)
    (mask_q == '0) |=> !irq); // R12
  AST_TXD_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    !tx_busy |-> txd); // R10
  AST_OVR_FROM_LOAD: assert property (@(posedge clk) disable iff (rst)
    $rose(status_q[7]) |-> $past(rx_load)); // R6
  AST_ADR_IN_MODE: assert property (@(posedge clk) disable iff (rst)
    $rose(status_q[4]) |-> $past(addr_mode)); // R8
  AST_BRK_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
    hw_set[3] |-> !rx_load); // R5
endmodule

bind sci_status_uart sci_status_uart_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SW(8)) u_chk (
  .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
  .status_q(status_q), .hw_set(hw_set), .mask_q(mask_q), .irq(irq), .txd(txd),
  .tx_busy(tx_busy), .rx_load(rx_load), .addr_mode(cfg_q.addr_mode)
);

// File: tb/sim_sci_status_uart.sv
`timescale 1ns/1ps
module sim_sci_status_uart;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick16 = 1'b1;
  logic       rxd = 1'b1;
  logic       txd;
  logic       cpu_wr = 1'b0;
  logic       cpu_rd = 1'b0;
  logic [2:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] cpu_rdata;
  logic       irq;

  int nchk = 0;
  int nerr = 0;

  always #4 clk = ~clk;

  sci_status_uart u0 (
    .clk(clk), .rst(rst), .tick16(tick16), .rxd(rxd), .txd(txd),
    .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .irq(irq)
  );

  function automatic logic par_of(input logic [7:0] d, input logic odd);
    return odd ? ~(^d) : ^d;
  endfunction

  task automatic check(input string tag, input logic [10:0] act, input logic [10:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    cpu_rd = 1'b1; cpu_addr = a;
    @(negedge clk);
    cpu_rd = 1'b0;
    d = cpu_rdata;
  endtask

  task automatic send(input logic [7:0] d, input logic use_par, input logic pbit, input logic stopb);
    @(negedge clk);
    rxd = 1'b0;
    repeat (16) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = d[i];
      repeat (16) @(negedge clk);
    end
    if (use_par) begin
      rxd = pbit;
      repeat (16) @(negedge clk);
    end
    rxd = stopb;
    repeat (16) @(negedge clk);
    rxd = 1'b1;
    repeat (20) @(negedge clk);
  endtask

  task automatic grab_tx(input int n, output logic [10:0] bits);
    int guard = 0;
    bits = '1;
    while (txd !== 1'b0 && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    repeat (8) @(negedge clk);
    bits[0] = txd;
    for (int k = 1; k < n; k++) begin
      repeat (16) @(negedge clk);
      bits[k] = txd;
    end
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [7:0]  v;
    logic [10:0] bits;
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R1 reset state
    check("R1 irq", {10'd0, irq}, 11'd0);
    check("R1 txd", {10'd0, txd}, 11'd1);
    rd(3'd1, v); check("R1 status", {3'd0, v}, 11'h03);

    // R2 R3 R4 random frames
    for (int i = 0; i < 24; i++) begin
      logic [7:0] d;
      logic pe, odd, badp, bads;
      logic [7:0] exp_st;
      int e;
      d = 8'($urandom);
      pe = 1'($urandom);
      odd = 1'($urandom);
      e = int'($urandom % 4);
      badp = (e == 1) && pe;
      bads = (e == 2);
      if (bads) d[0] = 1'b1;
      wr(3'd2, {6'd0, odd, pe});
      wr(3'd1, 8'h00);
      send(d, pe, par_of(d, odd) ^ badp, ~bads);
      exp_st = 8'h04 | (bads ? 8'h40 : 8'h00) | (badp ? 8'h20 : 8'h00);
      rd(3'd1, v); check("R2/R3/R4 status", {3'd0, v}, {3'd0, exp_st});
      rd(3'd0, v); check("R2 data", {3'd0, v}, {3'd0, d});
    end

    // R3 directed odd-parity error
    wr(3'd2, 8'h03); wr(3'd1, 8'h00);
    send(8'h0F, 1'b1, 1'b0, 1'b1);
    rd(3'd1, v); check("R3 odd parity err", {3'd0, v}, 11'h024);
    rd(3'd0, v);

    // R5 break
    wr(3'd2, 8'h01); wr(3'd1, 8'h00);
    send(8'h00, 1'b1, 1'b0, 1'b0);
    rd(3'd1, v); check("R5 break flags", {3'd0, v}, 11'h008);
    wr(3'd1, 8'h00);
    send(8'h3C, 1'b1, par_of(8'h3C, 1'b0), 1'b1);
    rd(3'd1, v); check("R5 resume status", {3'd0, v}, 11'h004);
    rd(3'd0, v); check("R5 resume data", {3'd0, v}, 11'h03C);

    // R6 overrun
    wr(3'd2, 8'h00); wr(3'd1, 8'h00);
    send(8'h11, 1'b0, 1'b0, 1'b1);
    send(8'h22, 1'b0, 1'b0, 1'b1);
    rd(3'd1, v); check("R6 overrun status", {3'd0, v}, 11'h084);
    rd(3'd0, v); check("R6 newest data", {3'd0, v}, 11'h022);

    // R7 selective clear and no software set
    wr(3'd1, 8'h7F);
    rd(3'd1, v); check("R7 clear OE only", {3'd0, v}, 11'h004);
    wr(3'd1, 8'hFB);
    rd(3'd1, v); check("R7 clear all", {3'd0, v}, 11'h000);
    wr(3'd1, 8'hFF);
    rd(3'd1, v); check("R7 no sw set", {3'd0, v}, 11'h000);
    send(8'h33, 1'b0, 1'b0, 1'b1);
    rd(3'd1, v); check("R6 no overrun after read", {3'd0, v}, 11'h004);
    rd(3'd0, v);

    // R12 interrupt mask
    wr(3'd4, 8'h04);
    repeat (3) @(negedge clk);
    check("R12 irq on", {10'd0, irq}, 11'd1);
    wr(3'd4, 8'h80);
    repeat (3) @(negedge clk);
    check("R12 irq masked", {10'd0, irq}, 11'd0);
    wr(3'd4, 8'h00);

    // R8 R9 address mode
    wr(3'd3, 8'h5A); wr(3'd2, 8'h04); wr(3'd1, 8'h00);
    send(8'h44, 1'b0, 1'b0, 1'b1);
    rd(3'd1, v); check("R8 ignored status", {3'd0, v}, 11'h000);
    rd(3'd0, v); check("R8 ignored data", {3'd0, v}, 11'h033);
    send(8'h5A, 1'b0, 1'b0, 1'b1);
    rd(3'd1, v); check("R8 match status", {3'd0, v}, 11'h014);
    rd(3'd0, v); check("R8 match data", {3'd0, v}, 11'h05A);
    wr(3'd1, 8'h00);
    wr(3'd4, 8'h40);
    send(8'h77, 1'b0, 1'b0, 1'b0);
    rd(3'd1, v); check("R9 frame err status", {3'd0, v}, 11'h044);
    rd(3'd0, v); check("R9 corrupted data", {3'd0, v}, 11'h077);
    check("R9 irq", {10'd0, irq}, 11'd1);
    wr(3'd4, 8'h00);

    // R10 R11 transmitter
    wr(3'd2, 8'h01); wr(3'd1, 8'h00);
    wr(3'd0, 8'hA5);
    grab_tx(11, bits);
    check("R10 tx frame even", bits, {1'b1, par_of(8'hA5, 1'b0), 8'hA5, 1'b0});
    repeat (12) @(negedge clk);
    rd(3'd1, v); check("R11 tx flags done", {3'd0, v}, 11'h003);
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h3C);
    repeat (40) @(negedge clk);
    rd(3'd1, v); check("R11 buffer empty mid frame", {3'd0, v}, 11'h002);
    repeat (200) @(negedge clk);
    rd(3'd1, v); check("R11 shifter empty", {3'd0, v}, 11'h003);
    for (int i = 0; i < 6; i++) begin
      logic [7:0] d;
      logic pe, odd;
      d = 8'($urandom);
      pe = 1'($urandom);
      odd = 1'($urandom);
      wr(3'd2, {6'd0, odd, pe});
      wr(3'd0, d);
      if (pe) begin
        grab_tx(11, bits);
        check("R10 tx parity", bits, {1'b1, par_of(d, odd), d, 1'b0});
      end else begin
        grab_tx(10, bits);
        check("R10 tx plain", bits, {2'b11, d, 1'b0});
      end
      repeat (12) @(negedge clk);
      check("R10 idle high", {10'd0, txd}, 11'd1);
    end

    finish_run();
  end
endmodule